// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Clock Divider

This block is a watchdog timer placed on a simple memory-mapped register bus made of an address, a write strobe, write data and registered read data. Software programs a control word, a reload value and a live down-counter. The input clock first passes through an 8-bit programmable prescaler and then through a fixed divider that software selects. Each divided tick decrements the counter by one.

When the counter runs out, the block can raise a sticky level interrupt, a fixed-length system reset pulse, or both. Each of these two responses has its own enable bit. Software keeps the system alive by writing the live counter before it runs out. That same write also clears a pending interrupt.

The reload value and the live count are separate registers. Software can therefore arm the first timeout and the timeout used after each expiry independently, before it sets the run bit.

Top module: `wdog_periph`

## Requirements
- R1: After synchronous reset the control word reads 0x8021, the reload and count registers read 0x8000, and both `irq_o` and `sys_rst_o` are low.
- R2: The registers sit at byte offsets 0x00 (control), 0x04 (reload) and 0x08 (count). Read data is registered: it shows the register addressed during the previous cycle. Control bits 1, 6 and 7, and any unmapped offset, read as zero.
- R3: The tick period is (P+1)*D input cycles. P is control bits [15:8]. D is chosen by control bits [4:3]: 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128.
- R4: Each tick lowers a non-zero count by one. A tick that finds the count at zero reloads it from the reload register, and that tick is the expiry event. A count of N therefore expires on tick N+1.
- R5: A write to the count register loads the written value at that clock edge. It takes priority over a tick on the same edge.
- R6: Control bit 5 is the run bit. While it is clear the count holds its value. The dividers restart from zero when the run bit is set, so the first tick lands exactly (P+1)*D cycles after the enabling write.
- R7: With control bit 2 set, expiry sets `irq_o`, which stays high until any write to the count register clears it. With bit 2 clear, expiry leaves `irq_o` low.
- R8: With control bit 0 set, expiry drives `sys_rst_o` high for exactly 128 input cycles, starting after the expiry edge. With bit 0 clear, expiry produces no pulse.
- R9: The reload and count registers are written independently, and each reads back its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits above 15 are ignored |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Sticky expiry interrupt |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
The hardest cases to reach are the ones that depend on exact cycle alignment inside the hidden divider chain. Examples are a keep-alive write that lands on the same edge as a tick, and the first tick after the run bit is set again. The stimulus reaches these by clearing the run bit, which zeroes both divider stages. From that point every tick edge can be counted from the enabling write. Writes and reads are then placed on a known cycle, including exactly on the 16th edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register byte offsets
  localparam int OFF_CTRL   = 'h0;
  localparam int OFF_RELOAD = 'h4;
  localparam int OFF_COUNT  = 'h8;
  // control field positions
  localparam int B_RSTEN  = 0;
  localparam int B_IRQEN  = 2;
  localparam int B_DIV_LO = 3;
  localparam int B_RUN    = 5;
  localparam int B_PS_LO  = 8;
  localparam int CTRL_W   = 16;
  localparam int DSEL_W   = 2;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hFF3D;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 16'h8021;
  // smallest fixed division expressed as a power of two (16)
  localparam int DIV_MIN_LOG2 = 4;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int PS_W   = 8,
  parameter int DSEL_W = 2,
  parameter int DMIN_L = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PS_W-1:0]   presc,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);
  localparam int DC_W = DMIN_L + (1 << DSEL_W) - 1;

  logic [PS_W-1:0] pcnt;
  logic [DC_W-1:0] dcnt;
  logic [DC_W-1:0] dlim;
  logic            pwrap;
  logic            dwrap;

  assign dlim  = DC_W'((1 << (DMIN_L + int'(dsel))) - 1);
  assign pwrap = (pcnt >= presc);
  assign dwrap = (dcnt >= dlim);
  assign tick  = run & pwrap & dwrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pwrap) begin
      pcnt <= '0;
      dcnt <= dwrap ? '0 : dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign expire  = tick & at_zero & ~load;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= RST_VAL;
    else if (load)      cnt <= load_val;
    else if (tick)      cnt <= at_zero ? reload_val : cnt - 1'b1;
  end
endmodule

// File: rtl/wdog_pulse_stretch.sv
module wdog_pulse_stretch #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int LC_W = $clog2(LEN + 1);

  logic [LC_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (trig) begin
      pulse <= 1'b1;
      left  <= LC_W'(LEN - 1);
    end else if (left != '0) begin
      left  <= left - 1'b1;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int PS_W    = 8,
  parameter int RST_CYC = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  import wdog_pkg::*;

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(16'h8000);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sel_ctrl, sel_reload, sel_count;
  logic              wr_count;
  logic              tick;
  logic              expire;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:CTRL_W];

  assign sel_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_reload = (bus_addr == ADDR_W'(OFF_RELOAD));
  assign sel_count  = (bus_addr == ADDR_W'(OFF_COUNT));
  assign wr_count   = bus_we & sel_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= CNT_RST;
    end else if (bus_we) begin
      if (sel_ctrl)   ctrl_q   <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
      if (sel_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  wdog_tick_gen #(
    .PS_W  (PS_W),
    .DSEL_W(DSEL_W),
    .DMIN_L(DIV_MIN_LOG2)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q[B_RUN]),
    .presc(ctrl_q[B_PS_LO +: PS_W]),
    .dsel (ctrl_q[B_DIV_LO +: DSEL_W]),
    .tick (tick)
  );

  wdog_down_counter #(
    .CNT_W  (CNT_W),
    .RST_VAL(CNT_RST)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (wr_count),
    .load_val  (bus_wdata[CNT_W-1:0]),
    .reload_val(reload_q),
    .cnt       (cnt_q),
    .expire    (expire)
  );

  wdog_pulse_stretch #(
    .LEN(RST_CYC)
  ) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .trig (expire & ctrl_q[B_RSTEN]),
    .pulse(sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                              irq_o <= 1'b0;
    else if (wr_count)                    irq_o <= 1'b0;
    else if (expire && ctrl_q[B_IRQEN])   irq_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (sel_ctrl)        bus_rdata <= DATA_W'(ctrl_q);
      else if (sel_reload) bus_rdata <= DATA_W'(reload_q);
      else if (sel_count)  bus_rdata <= DATA_W'(cnt_q);
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic [15:0]       ctrl_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              tick,
  input logic              expire
);
  logic        cwr;
  logic [15:0] hi_len;

  assign cwr = bus_we && (bus_addr == ADDR_W'(8));

  always_ff @(posedge clk) begin
    if (rst)            hi_len <= '0;
    else if (sys_rst_o) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  // R5: a count write loads on the next edge
  p_count_load_r5: assert property (@(posedge clk) disable iff (rst)
    cwr |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

  // R4: a tick lowers a non-zero count
  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q != '0 && !cwr) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4: a tick at zero reloads
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0 && !cwr) |=> cnt_q == $past(reload_q));

  // R6: stopped counter holds
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[5] && !cwr) |=> $stable(cnt_q));

  // R7: count write clears the interrupt
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    cwr |=> !irq_o);

  // R7: interrupt only rises with its enable
  p_irq_enable_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(ctrl_q[2]));

  // R7: enabled expiry raises the interrupt
  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q[2]) |=> irq_o);

  // R8: pulse only rises with its enable
  p_rst_enable_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(ctrl_q[0]));

  // R8: pulse lasts at least the fixed length
  p_rst_len_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(sys_rst_o) && !$past(rst)) |-> hi_len >= 16'(RST_CYC));
endmodule

bind wdog_periph wdog_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .RST_CYC(RST_CYC)
) u_wdog_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .irq_o    (irq_o),
  .sys_rst_o(sys_rst_o),
  .ctrl_q   (ctrl_q),
  .reload_q (reload_q),
  .cnt_q    (cnt_q),
  .tick     (tick),
  .expire   (expire)
);

// File: tb/tb_wdog_periph.sv
module tb_wdog_periph;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        sys_rst_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_issue = 1'b0;
  logic        rd_seen  = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CNT = 4'h8;

  wdog_periph dut (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .sys_rst_o(sys_rst_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data one cycle after the address was presented
  always @(posedge clk) rd_seen <= rd_issue;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  // all bus tasks start and end at a falling edge and take one cycle
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_issue = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({31'd0, irq_o}, 32'd0, "R1 irq after reset");
    chk({31'd0, sys_rst_o}, 32'd0, "R1 sys_rst after reset");
    rd(A_CTRL, 32'h8021, "R1 ctrl reset");
    rd(A_RLD,  32'h8000, "R1 reload reset");
    rd(A_CNT,  32'h8000, "R1 count reset");
    rd(4'hC,   32'h0,    "R2 unmapped offset");

    // R9 / R2 independent writes and read-back, undefined ctrl bits zero
    wr(A_CTRL, 32'hFFFF_00C2);
    rd(A_CTRL, 32'h0, "R2 reserved ctrl bits");
    wr(A_RLD, 32'h0003);
    wr(A_CNT, 32'h0005);
    rd(A_RLD, 32'h0003, "R9 reload value");
    rd(A_CNT, 32'h0005, "R9 count value");
    repeat (100) @(negedge clk);
    rd(A_CNT, 32'h0005, "R6 hold while stopped");

    // R3/R4/R7: count 5, P=0, D=16, irq on, reset off -> expiry at edge 96
    wr(A_CTRL, 32'h0024);
    repeat (95) @(negedge clk);
    chk({31'd0, irq_o}, 32'd0, "R4 irq before tick 6");
    @(negedge clk);
    chk({31'd0, irq_o}, 32'd1, "R7 irq on expiry");
    rd(A_CNT, 32'h0003, "R4 reload on expiry");
    repeat (20) @(negedge clk);
    chk({31'd0, irq_o}, 32'd1, "R7 irq sticky");
    chk({31'd0, sys_rst_o}, 32'd0, "R8 no pulse without enable");
    wr(A_CNT, 32'h0010);
    chk({31'd0, irq_o}, 32'd0, "R7 irq cleared by count write");
    wr(A_CTRL, 32'h0);

    // R6: stop mid-count and restart deterministically
    wr(A_RLD, 32'hFFFF);
    wr(A_CNT, 32'h0009);
    wr(A_CTRL, 32'h0020);
    repeat (39) @(negedge clk);
    wr(A_CTRL, 32'h0);            // lands on edge 40: count is 7
    repeat (200) @(negedge clk);
    rd(A_CNT, 32'h0007, "R6 held after stop");
    wr(A_CTRL, 32'h0020);
    repeat (14) @(negedge clk);
    rd(A_CNT, 32'h0007, "R6 before first tick");
    rd(A_CNT, 32'h0007, "R6 edge 16 not yet visible");
    rd(A_CNT, 32'h0006, "R6 first tick after restart");
    wr(A_CNT, 32'h1234);
    rd(A_CNT, 32'h1234, "R5 immediate load");
    wr(A_CTRL, 32'h0);

    // R5: count write on the same edge as a tick wins
    wr(A_CNT, 32'h0009);
    wr(A_CTRL, 32'h0020);
    repeat (15) @(negedge clk);
    wr(A_CNT, 32'h0050);          // lands on edge 16 (tick)
    rd(A_CNT, 32'h0050, "R5 write beats tick");
    wr(A_CTRL, 32'h0);

    // R3: each fixed divider with P=1, count 0 expires on first tick
    for (int d = 0; d < 4; d++) begin
      int per;
      per = 2 * (16 << d);
      wr(A_CTRL, 32'h0);
      wr(A_CNT, 32'h0);
      chk({31'd0, irq_o}, 32'd0, "R7 cleared before divider run");
      wr(A_CTRL, 32'h0124 | (32'(d) << 3));
      repeat (per - 1) @(negedge clk);
      chk({31'd0, irq_o}, 32'd0, "R3 divider early");
      @(negedge clk);
      chk({31'd0, irq_o}, 32'd1, "R3 divider period");
    end

    // R3: prescaler P=2 with D=128 and P=255 with D=16
    wr(A_CTRL, 32'h0); wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h023C);
    repeat (383) @(negedge clk);
    chk({31'd0, irq_o}, 32'd0, "R3 P2 D128 early");
    @(negedge clk);
    chk({31'd0, irq_o}, 32'd1, "R3 P2 D128 period");
    wr(A_CTRL, 32'h0); wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'hFF24);
    repeat (4095) @(negedge clk);
    chk({31'd0, irq_o}, 32'd0, "R3 P255 early");
    @(negedge clk);
    chk({31'd0, irq_o}, 32'd1, "R3 P255 period");

    // R8: reset pulse, count 1 expires at edge 32, 128 cycles high
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'h0001);
    wr(A_CTRL, 32'h0021);
    repeat (31) @(negedge clk);
    chk({31'd0, sys_rst_o}, 32'd0, "R8 pulse not yet");
    @(negedge clk);
    chk({31'd0, sys_rst_o}, 32'd1, "R8 pulse start");
    repeat (127) @(negedge clk);
    chk({31'd0, sys_rst_o}, 32'd1, "R8 pulse last cycle");
    @(negedge clk);
    chk({31'd0, sys_rst_o}, 32'd0, "R8 pulse end");
    chk({31'd0, irq_o}, 32'd0, "R7 no irq without enable");
    wr(A_CTRL, 32'h0);

    @(negedge clk);
    summary();
    $finish;
  end
endmodule